// File: doc/BRIEF.md
# Prioritized Interrupt Controller

This block gathers interrupt requests from a group of external pins and from internal sources (six timers, two DMA channels and ten serial transmit/receive lines). It forwards a single request line to the processor. Each source has its own 32-bit control word that holds an enable, a pending flag, a sense-mode code and a three-bit priority level. A global mask decides which levels may reach the processor. A status word reports which source currently wins arbitration.

Software reaches the block through a simple word-wide register port with a select, a write strobe and an address. Reads are combinational. External pins pass through a two-flop synchronizer before detection. Internal sources are already synchronous to the clock and are sampled directly. Reset must be applied asynchronously and released away from the clock edge by the surrounding reset logic.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset every control word reads 0x00000007 (enable clear, level 7, mode 00, no pending flag), the mask reads 0, the status reads 0 and `cpu_irq` is low.
- R2: Control word layout: bit 12 enable, bit 8 pending flag, bits 5:4 sense mode, bits 2:0 level. All other bits read as 0.
- R3: Address map: status at 0x004 (winning source number in bits 5:0), mask at 0x01C (field in bits 18:16), and the control word of source number s at 0x200 + 4*(s-1). Source numbers are as follows: external pins 0..6 are 1..7; internal inputs are taken in index order as 16..21 (timers), 32..33 (DMA) and 48..57 (serial).
- R4: Sense mode 00 sets the pending flag on a high-to-low transition and mode 10 sets it on a low-to-high transition. In these edge modes the flag stays set after the input returns.
- R5: Sense mode 01 makes the pending flag follow a low input and mode 11 makes it follow a high input.
- R6: In an edge mode, writing 0 to bit 8 clears the pending flag. Writing 1 to bit 8 has no effect.
- R7: A source at level 7 never raises `cpu_irq` and never appears in the status word.
- R8: A mask value N passes only levels below N, so a mask of 0 blocks every source.
- R9: A source with its enable bit clear still records its pending flag, but it cannot raise `cpu_irq`.
- R10: Among enabled, pending, unmasked sources, the lowest level wins, and a tie goes to the lowest source number. The status word holds the winner, or 0 when there is none, and `cpu_irq` is high exactly when a winner exists.
- R11: An external pin change shows in the pending flag on the third rising clock edge after the change and not before. An internal input change shows on the first rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | Write strobe (with select) |
| bus_addr | input | 12 | Byte address within the block |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from address |
| ext_irq | input | 7 | External interrupt pins, asynchronous |
| int_irq | input | 18 | Internal peripheral requests, synchronous |
| cpu_irq | output | 1 | Prioritized request to the processor |

## Verification
The bench walks a table of level and mask settings over three internal sources. The table covers level ties, level 7, a mask of zero and masks that sit exactly at a level. A design that compared with `<=` against the mask, or that broke ties toward the higher source number, would report the wrong status. Directed cases count clock edges through the external synchronizer: an extra or missing stage moves the flag by one edge. They also confirm that a rising edge is ignored in falling mode, that the edge flag sticks, and that writing 1 to the pending bit does not clear it. A disabled but pending source must show its flag while keeping `cpu_irq` low. An arbiter that dropped the enable term would raise the request early.

// File: rtl/pic_pkg.sv
package pic_pkg;

  localparam int unsigned EXT_BASE  = 1;
  localparam int unsigned TMR_BASE  = 16;
  localparam int unsigned DMA_BASE  = 32;
  localparam int unsigned SER_BASE  = 48;
  localparam int unsigned CTRL_BASE = 'h200;
  localparam int unsigned STAT_OFS  = 'h004;
  localparam int unsigned MASK_OFS  = 'h01C;
  localparam int unsigned LVL_W     = 3;
  localparam int unsigned SRC_W     = 6;

  typedef enum logic [1:0] {
    SENSE_FALL = 2'b00,
    SENSE_LOW  = 2'b01,
    SENSE_RISE = 2'b10,
    SENSE_HIGH = 2'b11
  } sense_t;

  // Source number of a source index; indices are packed externals first.
  function automatic int unsigned src_id(int unsigned idx, int unsigned n_ext,
                                         int unsigned n_tmr, int unsigned n_dma);
    if (idx < n_ext)                    return EXT_BASE + idx;
    else if (idx < n_ext + n_tmr)       return TMR_BASE + (idx - n_ext);
    else if (idx < n_ext + n_tmr + n_dma) return DMA_BASE + (idx - n_ext - n_tmr);
    else                                return SER_BASE + (idx - n_ext - n_tmr - n_dma);
  endfunction

endpackage

// File: rtl/pic_sync.sv
module pic_sync #(
  parameter int unsigned WIDTH  = 7,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);

  genvar b;
  generate
    for (b = 0; b < WIDTH; b++) begin : g_bit
      logic [STAGES-1:0] chain_q;
      logic [STAGES-1:0] chain_d;

      always_comb begin
        chain_d = {chain_q[STAGES-2:0], async_i[b]};
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
      end

      assign sync_o[b] = chain_q[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/pic_source.sv
module pic_source
  import pic_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sample_i,
  input  logic             wr_i,
  input  logic             wr_en_i,
  input  logic             wr_pend_i,
  input  logic [1:0]       wr_mode_i,
  input  logic [LVL_W-1:0] wr_lvl_i,
  output logic             en_o,
  output logic             pend_o,
  output logic [1:0]       mode_o,
  output logic [LVL_W-1:0] lvl_o
);

  logic             en_q, en_d;
  logic             pend_q, pend_d;
  sense_t           mode_q, mode_d;
  logic [LVL_W-1:0] lvl_q, lvl_d;
  logic             prev_q;
  logic             hit;
  logic             edge_mode;
  logic             sw_clear;

  assign edge_mode = ~mode_q[0];
  assign sw_clear  = wr_i & ~wr_pend_i;

  always_comb begin
    unique case (mode_q)
      SENSE_FALL: hit = prev_q & ~sample_i;
      SENSE_RISE: hit = ~prev_q & sample_i;
      SENSE_LOW:  hit = ~sample_i;
      default:    hit = sample_i;
    endcase
  end

  always_comb begin
    en_d   = en_q;
    mode_d = mode_q;
    lvl_d  = lvl_q;
    if (wr_i) begin
      en_d   = wr_en_i;
      mode_d = sense_t'(wr_mode_i);
      lvl_d  = wr_lvl_i;
    end
    if (edge_mode) pend_d = hit | (pend_q & ~sw_clear);
    else           pend_d = hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      pend_q <= 1'b0;
      mode_q <= SENSE_FALL;
      lvl_q  <= '1;
      prev_q <= 1'b0;
    end else begin
      en_q   <= en_d;
      pend_q <= pend_d;
      mode_q <= mode_d;
      lvl_q  <= lvl_d;
      prev_q <= sample_i;
    end
  end

  assign en_o   = en_q;
  assign pend_o = pend_q;
  assign mode_o = mode_q;
  assign lvl_o  = lvl_q;

  AST_EDGE_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_mode && pend_q && !sw_clear) |=> pend_q); // R4

  AST_LEVEL_FOLLOWS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == SENSE_HIGH && !wr_i) |=> (pend_q == $past(sample_i))); // R5

endmodule

// File: rtl/pic_arbiter.sv
module pic_arbiter
  import pic_pkg::*;
#(
  parameter int unsigned N_SRC = 25,
  localparam int unsigned IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [N_SRC-1:0]       en_i,
  input  logic [N_SRC-1:0]       pend_i,
  input  logic [N_SRC*LVL_W-1:0] lvl_i,
  input  logic [LVL_W-1:0]       mask_i,
  output logic                   found_o,
  output logic [IDX_W-1:0]       win_idx_o,
  output logic [LVL_W-1:0]       win_lvl_o
);

  logic [LVL_W-1:0] lvl_of [N_SRC];
  logic [N_SRC-1:0] elig;

  genvar g;
  generate
    for (g = 0; g < N_SRC; g++) begin : g_elig
      assign lvl_of[g] = lvl_i[g*LVL_W +: LVL_W];
      assign elig[g]   = en_i[g] & pend_i[g] & (lvl_of[g] < mask_i);
    end
  endgenerate

  // Ascending scan with strict compare: equal levels keep the lower index.
  always_comb begin
    found_o   = 1'b0;
    win_idx_o = '0;
    win_lvl_o = '1;
    for (int i = 0; i < N_SRC; i++) begin
      if (elig[i] && (!found_o || lvl_of[i] < win_lvl_o)) begin
        found_o   = 1'b1;
        win_idx_o = IDX_W'(i);
        win_lvl_o = lvl_of[i];
      end
    end
  end

  AST_MASK_ZERO_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_i == '0) |-> !found_o); // R8

  AST_WIN_BELOW_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    found_o |-> (win_lvl_o < mask_i)); // R8

  AST_LVL7_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    found_o |-> (win_lvl_o != '1)); // R7

  AST_WINNER_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
    found_o |-> (en_i[win_idx_o] && pend_i[win_idx_o])); // R9

endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import pic_pkg::*;
#(
  parameter int unsigned N_EXT  = 7,
  parameter int unsigned N_TMR  = 6,
  parameter int unsigned N_DMA  = 2,
  parameter int unsigned N_SER  = 10,
  parameter int unsigned ADDR_W = 12,
  localparam int unsigned N_INT = N_TMR + N_DMA + N_SER
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [N_EXT-1:0]  ext_irq,
  input  logic [N_INT-1:0]  int_irq,
  output logic              cpu_irq
);

  localparam int unsigned N_SRC = N_EXT + N_INT;
  localparam int unsigned IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1;
  localparam logic [ADDR_W-1:0] STAT_ADDR = ADDR_W'(STAT_OFS);
  localparam logic [ADDR_W-1:0] MASK_ADDR = ADDR_W'(MASK_OFS);

  logic [N_EXT-1:0]       ext_sync;
  logic [N_SRC-1:0]       sample;
  logic [N_SRC-1:0]       en_v, pend_v;
  logic [N_SRC*LVL_W-1:0] lvl_v;
  logic [1:0]             mode_v [N_SRC];
  logic [ADDR_W-1:0]      ctrl_addr [N_SRC];
  logic [SRC_W-1:0]       id_tab [N_SRC];
  logic [N_SRC-1:0]       ctrl_wr;
  logic [LVL_W-1:0]       mask_q, mask_d;
  logic                   wr_stb;
  logic                   found;
  logic [IDX_W-1:0]       win_idx;
  logic [LVL_W-1:0]       win_lvl;
  logic [SRC_W-1:0]       status;
  logic                   unused_wbits;

  assign wr_stb       = bus_sel & bus_wr;
  assign unused_wbits = ^{bus_wdata[31:19], bus_wdata[15:13], bus_wdata[11:9],
                          bus_wdata[7:6], bus_wdata[3], win_lvl};

  pic_sync #(.WIDTH(N_EXT), .STAGES(2)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .async_i(ext_irq),
    .sync_o (ext_sync)
  );

  assign sample = {int_irq, ext_sync};

  genvar s;
  generate
    for (s = 0; s < N_SRC; s++) begin : g_src
      localparam int unsigned SID = src_id(s, N_EXT, N_TMR, N_DMA);
      assign id_tab[s]    = SRC_W'(SID);
      assign ctrl_addr[s] = ADDR_W'(CTRL_BASE + 4 * (SID - 1));
      assign ctrl_wr[s]   = wr_stb & (bus_addr == ctrl_addr[s]);

      pic_source u_src (
        .clk      (clk),
        .rst_n    (rst_n),
        .sample_i (sample[s]),
        .wr_i     (ctrl_wr[s]),
        .wr_en_i  (bus_wdata[12]),
        .wr_pend_i(bus_wdata[8]),
        .wr_mode_i(bus_wdata[5:4]),
        .wr_lvl_i (bus_wdata[2:0]),
        .en_o     (en_v[s]),
        .pend_o   (pend_v[s]),
        .mode_o   (mode_v[s]),
        .lvl_o    (lvl_v[s*LVL_W +: LVL_W])
      );
    end
  endgenerate

  always_comb begin
    mask_d = mask_q;
    if (wr_stb && bus_addr == MASK_ADDR) mask_d = bus_wdata[18:16];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mask_q <= '0;
    else        mask_q <= mask_d;
  end

  pic_arbiter #(.N_SRC(N_SRC)) u_arb (
    .clk      (clk),
    .rst_n    (rst_n),
    .en_i     (en_v),
    .pend_i   (pend_v),
    .lvl_i    (lvl_v),
    .mask_i   (mask_q),
    .found_o  (found),
    .win_idx_o(win_idx),
    .win_lvl_o(win_lvl)
  );

  assign status  = found ? id_tab[win_idx] : '0;
  assign cpu_irq = found;

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == STAT_ADDR) begin
      bus_rdata[SRC_W-1:0] = status;
    end else if (bus_addr == MASK_ADDR) begin
      bus_rdata[18:16] = mask_q;
    end else begin
      for (int i = 0; i < N_SRC; i++) begin
        if (bus_addr == ctrl_addr[i]) begin
          bus_rdata[12]  = en_v[i];
          bus_rdata[8]   = pend_v[i];
          bus_rdata[5:4] = mode_v[i];
          bus_rdata[2:0] = lvl_v[i*LVL_W +: LVL_W];
        end
      end
    end
  end

  AST_IRQ_HAS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_irq |-> (status != '0)); // R10

  AST_QUIET_STATUS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_irq |-> (status == '0)); // R10

endmodule

// File: tb/prio_irq_ctrl_tb_top.sv
`timescale 1ns/1ps
module prio_irq_ctrl_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_sel, bus_wr;
  logic [11:0] bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic [6:0]  ext_irq;
  logic [17:0] int_irq;
  logic        cpu_irq;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  prio_irq_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ext_irq(ext_irq), .int_irq(int_irq), .cpu_irq(cpu_irq)
  );

  localparam logic [11:0] A_STAT = 12'h004;
  localparam logic [11:0] A_MASK = 12'h01C;

  function automatic logic [11:0] ctrl_a(int s);
    return 12'(32'h200 + 4 * (s - 1));
  endfunction

  // {mask, lvl16, lvl32, lvl48, expected source}
  localparam logic [17:0] VEC [10] = '{
    {3'd7, 3'd3, 3'd2, 3'd5, 6'd32},
    {3'd7, 3'd1, 3'd1, 3'd1, 6'd16},
    {3'd7, 3'd4, 3'd6, 3'd0, 6'd48},
    {3'd2, 3'd3, 3'd2, 3'd5, 6'd0},
    {3'd3, 3'd3, 3'd2, 3'd5, 6'd32},
    {3'd7, 3'd7, 3'd7, 3'd6, 6'd48},
    {3'd7, 3'd7, 3'd7, 3'd7, 6'd0},
    {3'd0, 3'd0, 3'd0, 3'd0, 6'd0},
    {3'd1, 3'd5, 3'd0, 3'd0, 6'd32},
    {3'd6, 3'd6, 3'd6, 3'd5, 6'd48}
  };

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    ext_irq = '0; int_irq = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  initial begin
    logic [31:0] v;

    // R1 reset state
    do_reset();
    rd(ctrl_a(1), v);  check("R1 ctrl1", v, 32'h7);
    rd(ctrl_a(16), v); check("R1 R3 ctrl16", v, 32'h7);
    rd(A_MASK, v);     check("R1 mask", v, 0);
    rd(A_STAT, v);     check("R1 status", v, 0);
    check("R1 cpu_irq", cpu_irq, 0);

    // R2 layout, R6 pending write of 1 ignored on a clear flag
    wr(ctrl_a(2), 32'hFFFF_FFFF);
    rd(ctrl_a(2), v);  check("R2 ctrl layout", v, 32'h1037);
    wr(A_MASK, 32'hFFFF_FFFF);
    rd(A_MASK, v);     check("R2 R3 mask field", v, 32'h0007_0000);

    // R4 falling edge, R11 sync latency, R6 clear
    do_reset();
    wr(ctrl_a(1), 32'h1002);
    wr(A_MASK, 32'h0007_0000);
    @(negedge clk) ext_irq[0] = 1'b1;
    repeat (5) @(posedge clk);
    rd(ctrl_a(1), v);  check("R4 rise ignored in fall mode", v, 32'h1002);
    @(negedge clk) ext_irq[0] = 1'b0;
    repeat (2) @(posedge clk);
    rd(ctrl_a(1), v);  check("R11 not before third edge", v, 32'h1002);
    rd(ctrl_a(1), v);  check("R11 R4 set on third edge", v, 32'h1102);
    check("R10 cpu_irq", cpu_irq, 1);
    rd(A_STAT, v);     check("R10 R3 status src1", v, 1);
    @(negedge clk) ext_irq[0] = 1'b1;
    repeat (5) @(posedge clk);
    rd(ctrl_a(1), v);  check("R4 sticky", v, 32'h1102);
    wr(ctrl_a(1), 32'h1102);
    rd(ctrl_a(1), v);  check("R6 write one no effect", v, 32'h1102);
    wr(ctrl_a(1), 32'h1002);
    rd(ctrl_a(1), v);  check("R6 write zero clears", v, 32'h1002);
    check("R6 cpu_irq low", cpu_irq, 0);

    // R4 rising edge pulse
    do_reset();
    wr(ctrl_a(3), 32'h1021);
    wr(A_MASK, 32'h0007_0000);
    @(negedge clk) ext_irq[2] = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk) ext_irq[2] = 1'b0;
    repeat (5) @(posedge clk);
    rd(ctrl_a(3), v);  check("R4 rise latched", v, 32'h1121);
    rd(A_STAT, v);     check("R4 R10 status src3", v, 3);

    // R5 low-level mode
    do_reset();
    wr(ctrl_a(4), 32'h1010);
    wr(A_MASK, 32'h0007_0000);
    repeat (4) @(posedge clk);
    rd(ctrl_a(4), v);  check("R5 low level pending", v, 32'h1110);
    @(negedge clk) ext_irq[3] = 1'b1;
    repeat (5) @(posedge clk);
    rd(ctrl_a(4), v);  check("R5 flag follows input", v, 32'h1010);
    check("R5 cpu_irq low", cpu_irq, 0);

    // R9 disabled source records but does not request
    do_reset();
    wr(ctrl_a(5), 32'h0030);
    wr(A_MASK, 32'h0007_0000);
    @(negedge clk) ext_irq[4] = 1'b1;
    repeat (5) @(posedge clk);
    rd(ctrl_a(5), v);  check("R9 pending recorded", v, 32'h0130);
    check("R9 cpu_irq low", cpu_irq, 0);
    rd(A_STAT, v);     check("R9 status zero", v, 0);
    wr(ctrl_a(5), 32'h1030);
    rd(A_STAT, v);     check("R9 enabled status", v, 5);

    // R11 internal input latency
    do_reset();
    wr(ctrl_a(16), 32'h1030);
    @(negedge clk) int_irq[0] = 1'b1;
    @(posedge clk);
    rd(ctrl_a(16), v); check("R11 internal one edge", v, 32'h1130);

    // R7 R8 R10 arbitration table
    do_reset();
    @(negedge clk) begin int_irq[0] = 1'b1; int_irq[6] = 1'b1; int_irq[8] = 1'b1; end
    for (int k = 0; k < 10; k++) begin
      wr(A_MASK, {13'd0, VEC[k][17:15], 16'd0});
      wr(ctrl_a(16), 32'h1030 | 32'(VEC[k][14:12]));
      wr(ctrl_a(32), 32'h1030 | 32'(VEC[k][11:9]));
      wr(ctrl_a(48), 32'h1030 | 32'(VEC[k][8:6]));
      rd(A_STAT, v);
      check($sformatf("R10 R8 R7 R3 vec %0d status", k), v, 32'(VEC[k][5:0]));
      check($sformatf("R10 vec %0d cpu_irq", k), cpu_irq, (VEC[k][5:0] != 0));
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule